// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is a 4-bit counter whose state bits all change together on the rising clock edge. It can be preset from a parallel data input and cleared by an active-low clear. Two parameters fix how it is built. One picks binary counting (0 to 15) or decade counting (0 to 9). The other picks a clear that acts on the clock edge or a clear that acts at once.

Counting needs two enables, a parallel enable and a trickle enable, and both must be high. Only the trickle enable feeds the carry output. The carry is high while the trickle enable is high and the count sits at its terminal value. Several instances can therefore be chained into a wider synchronous counter with no extra gating. In that chain each carry drives the next stage's trickle enable, and one common count-enable drives every parallel enable. The least significant stage takes the common enable on both of its enable inputs.

Top module: `sync_preset_counter`

## Requirements
- R1: With clr_n and load_n high and both en_p and en_t high at a rising edge, q increases by one on that edge.
- R2: With clr_n and load_n high and either enable low at a rising edge, q keeps its value.
- R3: With clr_n high and load_n low at a rising edge, q takes din on that edge, whatever the enables are.
- R4: In the edge-clear build (ASYNC_CLR=0), clr_n low at a rising edge sets q to 0 on that edge and not before, overriding load_n and both enables.
- R5: In the immediate-clear build (ASYNC_CLR=1), q is 0 as soon as clr_n goes low, with no clock edge, and it stays 0 while clr_n is low.
- R6: A counting edge at the terminal value (15 when DECADE=0, 9 when DECADE=1) takes q to 0.
- R7: carry_out is 1 exactly when en_t is 1 and q equals the terminal value. It follows en_t with no clock edge, and en_p has no effect on it.
- R8: With DECADE=1, a loaded value from 10 to 15 goes to 0 on the next counting edge, and carry_out stays 0 while q holds such a value.
- R9: Pulses on load_n, en_p or din that end before a rising edge leave q unchanged. Only the levels at the edge decide whether q loads, counts or holds.
- R10: Three stages chained through carry_out into en_t, with a common enable on en_p, count as one 12-bit binary counter or a 3-digit decimal counter. This holds across every stage wrap, and the last carry rises only at the all-terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Clear, active low; edge or immediate depending on ASYNC_CLR |
| load_n | input | 1 | Parallel preset, active low, sampled at the edge |
| din | input | W | Preset value |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable, also gates carry_out |
| q | output | W | Current count |
| carry_out | output | 1 | High while en_t is high and q is at the terminal value |

## Verification
Loading, counting, holding and the edge clear take effect on the first rising edge after the inputs are set up. The bench drives inputs 2 time units after an edge and reads q 2 time units after the next edge, once every register on the path has settled. carry_out and the immediate clear need no edge, so they are read 1 time unit after the inputs change, well before the next edge. The same half-cycle gap holds the old value while a pulse on the controls comes and goes between edges.

// File: rtl/cntr_pkg.sv
package cntr_pkg;

  // Operation selected for the coming clock edge, highest priority last.
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  // Terminal count for a given width and counting base.
  function automatic int unsigned wrap_limit(input int unsigned width, input bit decade);
    if (decade) return 32'd9;
    return (32'd1 << width) - 32'd1;
  endfunction

  // True when the value sits exactly on the terminal count.
  function automatic bit is_terminal(input int unsigned value, input int unsigned limit);
    return value == limit;
  endfunction

  // One counting step; anything at or past the limit returns to zero.
  function automatic int unsigned step_value(input int unsigned value, input int unsigned limit);
    if (value >= limit) return 32'd0;
    return value + 32'd1;
  endfunction

endpackage

// File: rtl/cntr_op_decode.sv
module cntr_op_decode (
  input  logic              clr_n,
  input  logic              load_n,
  input  logic              en_p,
  input  logic              en_t,
  output cntr_pkg::cnt_op_e op,
  output logic              clear_fire,
  output logic              load_fire,
  output logic              count_fire
);
  import cntr_pkg::*;

  // Named events, one per operation, in priority order.
  assign clear_fire = !clr_n;
  assign load_fire  = clr_n && !load_n;
  assign count_fire = clr_n && load_n && en_p && en_t;

  always_comb begin
    if (clear_fire)      op = OP_CLEAR;
    else if (load_fire)  op = OP_LOAD;
    else if (count_fire) op = OP_COUNT;
    else                 op = OP_HOLD;
  end
endmodule

// File: rtl/cntr_next_state.sv
module cntr_next_state #(
  parameter int unsigned W     = 4,
  parameter int unsigned LIMIT = 15
) (
  input  cntr_pkg::cnt_op_e op,
  input  logic [W-1:0]      q,
  input  logic [W-1:0]      din,
  output logic [W-1:0]      nxt
);
  import cntr_pkg::*;

  logic [W-1:0] stepped;

  assign stepped = W'(step_value(32'(q), LIMIT));

  always_comb begin
    unique case (op)
      OP_CLEAR: nxt = '0;
      OP_LOAD:  nxt = din;
      OP_COUNT: nxt = stepped;
      default:  nxt = q;
    endcase
  end
endmodule

// File: rtl/cntr_state_reg.sv
module cntr_state_reg #(
  parameter int unsigned W         = 4,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q <= '0;
        else        q <= nxt;
      end
    end else begin : g_sync
      // Clear already arrives through nxt; the select keeps it on the edge.
      always_ff @(posedge clk) begin
        q <= clr_n ? nxt : '0;
      end
    end
  endgenerate
endmodule

// File: rtl/cntr_carry_gen.sv
module cntr_carry_gen #(
  parameter int unsigned W     = 4,
  parameter int unsigned LIMIT = 15
) (
  input  logic [W-1:0] q,
  input  logic         en_t,
  output logic         at_limit,
  output logic         carry_out
);
  import cntr_pkg::*;

  assign at_limit  = is_terminal(32'(q), LIMIT);
  assign carry_out = en_t & at_limit;
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter #(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic [W-1:0] din,
  input  logic         en_p,
  input  logic         en_t,
  output logic [W-1:0] q,
  output logic         carry_out
);
  import cntr_pkg::*;

  localparam int unsigned LIMIT = wrap_limit(W, DECADE);

  cnt_op_e      op;
  logic         clear_fire;
  logic         load_fire;
  logic         count_fire;
  logic         at_limit;
  logic [W-1:0] nxt;

  cntr_op_decode u_dec (
    .clr_n      (clr_n),
    .load_n     (load_n),
    .en_p       (en_p),
    .en_t       (en_t),
    .op         (op),
    .clear_fire (clear_fire),
    .load_fire  (load_fire),
    .count_fire (count_fire)
  );

  cntr_next_state #(.W(W), .LIMIT(LIMIT)) u_nxt (
    .op  (op),
    .q   (q),
    .din (din),
    .nxt (nxt)
  );

  cntr_state_reg #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_reg (
    .clk   (clk),
    .clr_n (clr_n),
    .nxt   (nxt),
    .q     (q)
  );

  cntr_carry_gen #(.W(W), .LIMIT(LIMIT)) u_carry (
    .q         (q),
    .en_t      (en_t),
    .at_limit  (at_limit),
    .carry_out (carry_out)
  );
endmodule

// File: rtl/cntr_checker.sv
module cntr_checker #(
  parameter int unsigned W         = 4,
  parameter bit          DECADE    = 1'b0,
  parameter bit          ASYNC_CLR = 1'b0
) (
  input logic         clk,
  input logic         clr_n,
  input logic         load_n,
  input logic         en_p,
  input logic         en_t,
  input logic [W-1:0] din,
  input logic [W-1:0] q,
  input logic         carry_out,
  input logic         at_limit
);
  localparam logic [W-1:0] LIM = W'(cntr_pkg::wrap_limit(W, DECADE));

  logic clr_d;
  always_ff @(posedge clk) clr_d <= clr_n;

  // R1: a counting edge below the limit adds one
  a_r1_count_step: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q < LIM) |=> q == $past(q) + 1'b1);

  // R2: no count without both enables
  a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_p && en_t)) |=> $stable(q));

  // R3: load takes din regardless of enables
  a_r3_load: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> q == $past(din));

  // R4: the edge after clear was seen low finds q at zero
  a_r4_clear_lands: assert property (@(posedge clk) disable iff (!clr_n)
    (!clr_d) |-> q == '0);

  // R5: immediate clear holds q at zero between edges
  always @(negedge clk) begin
    if (ASYNC_CLR && !clr_n)
      a_r5_async_clear: assert (q == '0) else $error("R5 q not cleared");
  end

  // R6: counting at or beyond the limit returns to zero
  a_r6_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_p && en_t && q >= LIM) |=> q == '0);

  // R7: carry only with en_t and a terminal count, and always then
  a_r7_carry_needs_ent: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out |-> (en_t && at_limit && q == LIM));
  a_r7_carry_at_limit: assert property (@(posedge clk) disable iff (!clr_n)
    (en_t && q == LIM) |-> carry_out);

  generate
    if (DECADE) begin : g_dec
      // R8: over-range decade values never raise carry
      a_r8_no_carry_overrange: assert property (@(posedge clk) disable iff (!clr_n)
        (q > LIM) |-> !carry_out);
    end
  endgenerate
endmodule

bind sync_preset_counter cntr_checker #(.W(W), .DECADE(DECADE), .ASYNC_CLR(ASYNC_CLR)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .load_n    (load_n),
  .en_p      (en_p),
  .en_t      (en_t),
  .din       (din),
  .q         (q),
  .carry_out (carry_out),
  .at_limit  (at_limit)
);

// File: tb/sim_sync_preset_counter.sv
module sim_sync_preset_counter;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // single stages: u0 binary edge-clear, u1 decade immediate-clear
  logic       clr_n, load_n, en_p, en_t;
  logic [3:0] din;
  wire  [3:0] q0, q1;
  wire        co0, co1;
  int         m0, m1;

  sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q0), .carry_out(co0));

  sync_preset_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q1), .carry_out(co1));

  // three-stage chains
  logic            cc_clr_n, cc_load_n, cc_en;
  logic [2:0][3:0] cb_din, cd_din;
  wire  [2:0][3:0] cb_q, cd_q;
  wire  [2:0]      cb_co, cd_co, cb_ent, cd_ent;

  for (genvar k = 0; k < 3; k++) begin : g_chain
    if (k == 0) begin : g_lsb
      assign cb_ent[k] = cc_en;
      assign cd_ent[k] = cc_en;
    end else begin : g_upper
      assign cb_ent[k] = cb_co[k-1];
      assign cd_ent[k] = cd_co[k-1];
    end
    sync_preset_counter #(.W(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u_b (
      .clk(clk), .clr_n(cc_clr_n), .load_n(cc_load_n), .din(cb_din[k]),
      .en_p(cc_en), .en_t(cb_ent[k]), .q(cb_q[k]), .carry_out(cb_co[k]));
    sync_preset_counter #(.W(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u_d (
      .clk(clk), .clr_n(cc_clr_n), .load_n(cc_load_n), .din(cd_din[k]),
      .en_p(cc_en), .en_t(cd_ent[k]), .q(cd_q[k]), .carry_out(cd_co[k]));
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // expected next values restated from the requirements
  function automatic int exp_bin(input int x);
    if (!clr_n)             return 0;
    if (!load_n)            return int'(din);
    if (en_p && en_t)       return (x + 1) % 16;
    return x;
  endfunction

  function automatic int exp_dec(input int x);
    if (!clr_n)             return 0;
    if (!load_n)            return int'(din);
    if (en_p && en_t)       return (x < 9) ? x + 1 : 0;
    return x;
  endfunction

  function automatic string tag_of(input int x, input int lim);
    if (!load_n)            return "R3";
    if (!(en_p && en_t))    return "R2";
    if (x == lim)           return "R6";
    if (x > lim)            return "R8";
    return "R1";
  endfunction

  task automatic tick_model();
    int n0, n1;
    n0 = exp_bin(m0);
    n1 = exp_dec(m1);
    @(posedge clk);
    #2;
    m0 = n0;
    m1 = n1;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bin, dec;
    string t0, t1;
    clr_n = 1'b0; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
    cc_clr_n = 1'b0; cc_load_n = 1'b1; cc_en = 1'b0;
    cb_din = '0; cd_din = '0;
    m0 = 0; m1 = 0;
    tick_model();
    tick_model();
    check("R4 reset", int'(q0), 0);
    check("R5 reset", int'(q1), 0);

    // near-exhaustive sweep: every start value against every control pattern
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 8; c++) begin
        clr_n = 1'b1; load_n = 1'b0; din = 4'(v);
        en_p = c[1]; en_t = c[0];
        tick_model();
        check("R3 bin load", int'(q0), m0);
        check("R3 dec load", int'(q1), m1);
        load_n = c[2]; en_p = c[1]; en_t = c[0]; din = 4'(15 - v);
        #1;
        check("R7 bin carry", int'(co0), int'(en_t && m0 == 15));
        check((m1 > 9) ? "R8 dec carry" : "R7 dec carry", int'(co1), int'(en_t && m1 == 9));
        // carry ignores en_p
        en_p = ~en_p;
        #1;
        check("R7 en_p no effect", int'(co0), int'(en_t && m0 == 15));
        en_p = c[1];
        t0 = tag_of(m0, 15);
        t1 = tag_of(m1, 9);
        tick_model();
        check(t0, int'(q0), m0);
        check(t1, int'(q1), m1);
      end
    end

    // clear: immediate build drops at once, edge build waits for the edge
    clr_n = 1'b1; load_n = 1'b0; din = 4'd6; en_p = 1'b1; en_t = 1'b1;
    tick_model();
    clr_n = 1'b0; load_n = 1'b0; din = 4'd11;
    #1;
    check("R5 immediate", int'(q1), 0);
    check("R4 not before edge", int'(q0), 6);
    m1 = 0;
    tick_model();
    check("R4 clear beats load", int'(q0), 0);
    check("R5 held", int'(q1), 0);
    load_n = 1'b1;
    tick_model();
    check("R4 clear beats count", int'(q0), 0);
    check("R5 held over edge", int'(q1), 0);
    clr_n = 1'b1;
    tick_model();
    check("R1 after clear", int'(q0), 1);
    check("R1 after clear dec", int'(q1), 1);

    // pulses between edges leave the count alone
    load_n = 1'b0; din = 4'd3;
    tick_model();
    load_n = 1'b0; din = 4'd9; en_p = 1'b0;
    #2;
    check("R9 mid-cycle bin", int'(q0), 3);
    check("R9 mid-cycle dec", int'(q1), 3);
    load_n = 1'b1; din = 4'd3; en_p = 1'b1;
    tick_model();
    check("R9 edge level bin", int'(q0), 4);
    check("R9 edge level dec", int'(q1), 4);

    // three-stage chains in both modes
    tick();
    cc_clr_n = 1'b1; cc_load_n = 1'b0;
    cb_din[0] = 4'hC; cb_din[1] = 4'hE; cb_din[2] = 4'hF;
    cd_din[0] = 4'd7; cd_din[1] = 4'd8; cd_din[2] = 4'd9;
    tick();
    bin = 4076; dec = 987;
    check("R10 bin preset", int'({cb_q[2], cb_q[1], cb_q[0]}), bin);
    check("R10 dec preset", int'(cd_q[2]) * 100 + int'(cd_q[1]) * 10 + int'(cd_q[0]), dec);
    cc_load_n = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cc_en = (i % 7) != 3;
      #1;
      check("R10 bin top carry", int'(cb_co[2]), int'(cc_en && bin == 4095));
      check("R10 dec top carry", int'(cd_co[2]), int'(cc_en && dec == 999));
      if (cc_en) begin
        bin = (bin + 1) % 4096;
        dec = (dec + 1) % 1000;
      end
      tick();
      check("R10 bin chain", int'({cb_q[2], cb_q[1], cb_q[0]}), bin);
      check("R10 dec chain", int'(cd_q[2]) * 100 + int'(cd_q[1]) * 10 + int'(cd_q[0]), dec);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule